// File: doc/BRIEF.md
# Four-channel shadowed PWM generator

The block produces four pulse-width-modulated outputs from one shared 12-bit count. A single prescaler sets how many clock cycles each count step lasts, so all four channels always run with the same period. Each channel turns active when the count reaches its own ON value and turns inactive when the count reaches its own OFF value. Software programs the block one byte at a time through a small write port that carries an address, a data byte, a write strobe and a pulse that marks the end of a bus transaction.

New channel values never change a waveform partway through. Byte writes land in per-channel shadow registers. In the default mode, the end-of-transaction pulse moves a complete shadow set into a staging register. In acknowledge mode, the staging register is loaded once all four bytes of that channel have been written. A staged set becomes active only when the channel's low phase ends. Global controls cover sleep, output inversion, per-channel enable and a restart bit. The prescaler accepts writes only while the block is asleep.

Top module: `pwm4_shadow`

## Requirements
- R1: All channels share one 12-bit counter that wraps from 4095 to 0. Each count step lasts (P+1) clock cycles, where P is the prescale value, so every channel has a period of 4096*(P+1) cycles.
- R2: A running, enabled channel goes active at count ON and inactive at count OFF. Its active time per period is ((OFF-ON) mod 4096)*(P+1) cycles. When ON equals OFF, the channel stays inactive.
- R3: Register map. Address 0x00 is control: bit0 sleep (1 after reset), bit1 invert, bit2 acknowledge mode, bit3 restart. Address 0x01 holds the channel enables in bits 3:0. Address 0x02 holds the 8-bit prescale value, which resets to 0. Channel c uses addresses 0x08+4c+k: k=0 is ON[7:0], k=1 is ON[11:8] in data bits 3:0, k=2 is OFF[7:0], and k=3 is OFF[11:8] in data bits 3:0.
- R4: A staged setting becomes active only at the end of the channel's low phase, which is the cycle in which the count equals the current ON value while the output is inactive. A pulse already in progress finishes with the old values. While a channel is not producing pulses, its staged setting applies at once.
- R5: In the default mode, written bytes have no effect until an end-of-transaction pulse arrives. All bytes written before that pulse then apply together.
- R6: In acknowledge mode, a channel's setting is staged only after all four of its bytes have been written, in any order. The end-of-transaction pulse is ignored. A partially written set is never applied.
- R7: A disabled channel drives the constant inactive level.
- R8: The inactive level is low when invert is 0 and high when invert is 1. Active levels are inverted to match.
- R9: Writes to the prescale register while awake are ignored. Writes while asleep take effect.
- R10: While asleep, all outputs sit at the inactive level and the counter is held at 0.
- R11: After sleep is cleared, the outputs stay inactive and the count stays at 0 until a control write sets restart with sleep 0. Stored channel values survive sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register address of the write |
| reg_wdata | input | 8 | Data byte of the write |
| reg_wr | input | 1 | Write strobe, one byte per cycle |
| xact_end | input | 1 | Single-cycle end-of-transaction pulse |
| pwm_out | output | 4 | Channel outputs, bit c is channel c |

## Verification
The hardest case to create from the ports is a rewrite that arrives while a pulse is high, followed by a commit that must wait for the next low-to-high point. The stimulus watches channel 0, waits for its rising edge, and then writes new values partway through the pulse. A scoreboard expects one more pulse of the old width and then pulses of the new width. A second hard case is a partial byte set in acknowledge mode. The stimulus writes three of the four bytes right after a falling edge, adds an end-of-transaction pulse, and then expects the old pulse width to continue until the fourth byte arrives.

// File: rtl/pwm4_pkg.sv
// Shared constants and types for the four-channel shadowed PWM.
// Assumes byte-wide register data and channel blocks of four addresses.
package pwm4_pkg;
    localparam int BYTE_W      = 8;
    localparam int REG_CTRL    = 0;
    localparam int REG_ENA     = 1;
    localparam int REG_PRESC   = 2;
    localparam int CTL_SLEEP   = 0;
    localparam int CTL_INV     = 1;
    localparam int CTL_ACK     = 2;
    localparam int CTL_RESTART = 3;
    localparam int SLOTS       = 4;

    // Byte position inside a channel's four-address block.
    typedef enum logic [1:0] {
        SLOT_ON_LO  = 2'd0,
        SLOT_ON_HI  = 2'd1,
        SLOT_OFF_LO = 2'd2,
        SLOT_OFF_HI = 2'd3
    } slot_e;
endpackage

// File: rtl/pwm4_regs.sv
// Register front end: global controls, prescale, per-channel shadow bytes,
// and the pulse that loads the shadow set into a channel's staging register.
// Assumes CH_BASE is a multiple of 4, 9 <= CNT_W <= 16 and NCH <= 8.
module pwm4_regs
    import pwm4_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int CNT_W   = 12,
    parameter int PRE_W   = 8,
    parameter int ADDR_W  = 8,
    parameter int CH_BASE = 8,
    parameter int PRE_RST = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [BYTE_W-1:0]          wdata,
    input  logic                       wr,
    input  logic                       xend,
    output logic                       sleep_o,
    output logic                       inv_o,
    output logic                       run_o,
    output logic [NCH-1:0]             en_o,
    output logic [PRE_W-1:0]           presc_o,
    output logic [NCH-1:0][CNT_W-1:0]  shd_on_o,
    output logic [NCH-1:0][CNT_W-1:0]  shd_off_o,
    output logic [NCH-1:0]             ld_o
);
    localparam int HI_W = CNT_W - BYTE_W;

    logic ctl_hit, ena_hit, pre_hit, ack_q;

    assign ctl_hit = wr && (addr == ADDR_W'(REG_CTRL));
    assign ena_hit = wr && (addr == ADDR_W'(REG_ENA));
    assign pre_hit = wr && (addr == ADDR_W'(REG_PRESC));

    // Control register; restart sets run only together with sleep 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sleep_o <= 1'b1;
            inv_o   <= 1'b0;
            ack_q   <= 1'b0;
            run_o   <= 1'b0;
        end else if (ctl_hit) begin
            sleep_o <= wdata[CTL_SLEEP];
            inv_o   <= wdata[CTL_INV];
            ack_q   <= wdata[CTL_ACK];
            run_o   <= !wdata[CTL_SLEEP] && (wdata[CTL_RESTART] || run_o);
        end
    end

    // Channel enables.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_o <= '0;
        else if (ena_hit) en_o <= wdata[NCH-1:0];
    end

    // Prescale register, writable only while asleep.
    always_ff @(posedge clk) begin
        if (!rst_n)                  presc_o <= PRE_W'(PRE_RST);
        else if (pre_hit && sleep_o) presc_o <= wdata[PRE_W-1:0];
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(CH_BASE + SLOTS * c);
        logic             hit;
        slot_e            slot;
        logic [SLOTS-1:0] seen, seen_nx;
        logic             dirty, ld_r, full;
        logic [CNT_W-1:0] on_r, off_r;

        assign hit     = wr && (addr[ADDR_W-1:2] == BASE[ADDR_W-1:2]);
        assign slot    = slot_e'(addr[1:0]);
        assign seen_nx = seen | (SLOTS'(1) << addr[1:0]);
        assign full    = hit && (seen_nx == {SLOTS{1'b1}});

        // Shadow byte capture.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                on_r  <= '0;
                off_r <= '0;
            end else if (hit) begin
                case (slot)
                    SLOT_ON_LO:  on_r[BYTE_W-1:0]      <= wdata;
                    SLOT_ON_HI:  on_r[CNT_W-1:BYTE_W]  <= wdata[HI_W-1:0];
                    SLOT_OFF_LO: off_r[BYTE_W-1:0]     <= wdata;
                    default:     off_r[CNT_W-1:BYTE_W] <= wdata[HI_W-1:0];
                endcase
            end
        end

        // Completeness tracking and the load pulse to the staging register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seen  <= '0;
                dirty <= 1'b0;
                ld_r  <= 1'b0;
            end else if (ack_q) begin
                ld_r  <= full;
                dirty <= 1'b0;
                if (hit) seen <= full ? '0 : seen_nx;
            end else begin
                ld_r  <= xend && (dirty || hit);
                dirty <= !xend && (dirty || hit);
                seen  <= '0;
            end
        end

        assign shd_on_o[c]  = on_r;
        assign shd_off_o[c] = off_r;
        assign ld_o[c]      = ld_r;
    end
endmodule

// File: rtl/pwm4_timebase.sv
// Shared prescaler and wrapping count. Both are held at zero while not running.
// Assumes the prescale value changes only while stopped.
module pwm4_timebase #(
    parameter int CNT_W = 12,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] presc,
    output logic [CNT_W-1:0] cnt
);
    logic [PRE_W-1:0] pcnt;

    // Advance the count once every presc+1 cycles while running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pcnt <= '0;
            cnt  <= '0;
        end else if (pcnt == presc) begin
            pcnt <= '0;
            cnt  <= cnt + 1'b1;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwm4_chan.sv
// One PWM channel: the staging register, the active ON/OFF pair, and the level.
// Commits the staged pair only where the low phase ends, or at once while idle.
// Assumes the ld pulse comes one cycle after the shadow values are complete.
module pwm4_chan #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             inv,
    input  logic [CNT_W-1:0] cnt,
    input  logic             ld,
    input  logic [CNT_W-1:0] shd_on,
    input  logic [CNT_W-1:0] shd_off,
    output logic             pwm_o
);
    logic [CNT_W-1:0] stg_on, stg_off, act_on, act_off, eff_on, eff_off;
    logic             pend, lvl, lvl_nx, commit;

    assign commit  = pend && (!active || (!lvl && (cnt == act_on)));
    assign eff_on  = commit ? stg_on  : act_on;
    assign eff_off = commit ? stg_off : act_off;

    // Next level: OFF match wins over ON match.
    always_comb begin
        if (!active)              lvl_nx = 1'b0;
        else if (cnt == eff_off)  lvl_nx = 1'b0;
        else if (cnt == eff_on)   lvl_nx = 1'b1;
        else                      lvl_nx = lvl;
    end

    // Staging register and its pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_on  <= '0;
            stg_off <= '0;
            pend    <= 1'b0;
        end else begin
            if (ld) begin
                stg_on  <= shd_on;
                stg_off <= shd_off;
            end
            pend <= ld || (pend && !commit);
        end
    end

    // Active pair, replaced only on a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_on  <= '0;
            act_off <= '0;
        end else if (commit) begin
            act_on  <= stg_on;
            act_off <= stg_off;
        end
    end

    // Output level register.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl <= 1'b0;
        else        lvl <= lvl_nx;
    end

    assign pwm_o = (active && lvl) ^ inv;
endmodule

// File: rtl/pwm4_shadow.sv
// Top of the four-channel shadowed PWM: register front end, shared timebase,
// and one channel per output. Assumes writes arrive one byte per cycle.
module pwm4_shadow
    import pwm4_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int CNT_W   = 12,
    parameter int PRE_W   = 8,
    parameter int ADDR_W  = 8,
    parameter int CH_BASE = 8,
    parameter int PRE_RST = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  logic              reg_wr,
    input  logic              xact_end,
    output logic [NCH-1:0]    pwm_out
);
    logic                      sleep_w, inv_w, run_w;
    logic [NCH-1:0]            en_w, ld_w;
    logic [PRE_W-1:0]          presc_w;
    logic [CNT_W-1:0]          cnt_w;
    logic [NCH-1:0][CNT_W-1:0] shd_on_w, shd_off_w;

    pwm4_regs #(
        .NCH(NCH), .CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W),
        .CH_BASE(CH_BASE), .PRE_RST(PRE_RST)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata),
        .wr(reg_wr), .xend(xact_end), .sleep_o(sleep_w), .inv_o(inv_w),
        .run_o(run_w), .en_o(en_w), .presc_o(presc_w),
        .shd_on_o(shd_on_w), .shd_off_o(shd_off_w), .ld_o(ld_w)
    );

    pwm4_timebase #(.CNT_W(CNT_W), .PRE_W(PRE_W)) i_tb (
        .clk(clk), .rst_n(rst_n), .run(run_w), .presc(presc_w), .cnt(cnt_w)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        pwm4_chan #(.CNT_W(CNT_W)) i_chan (
            .clk(clk), .rst_n(rst_n), .active(run_w && en_w[c]), .inv(inv_w),
            .cnt(cnt_w), .ld(ld_w[c]), .shd_on(shd_on_w[c]),
            .shd_off(shd_off_w[c]), .pwm_o(pwm_out[c])
        );
    end
endmodule

// File: rtl/pwm4_shadow_chk.sv
// Property checker for pwm4_shadow, attached through bind below.
module pwm4_shadow_chk #(
    parameter int NCH   = 4,
    parameter int CNT_W = 12,
    parameter int PRE_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sleep,
    input logic             inv,
    input logic             run,
    input logic [NCH-1:0]   en,
    input logic [PRE_W-1:0] presc,
    input logic [CNT_W-1:0] cnt,
    input logic [NCH-1:0]   pwm_out
);
    // R10: asleep means every output is at the inactive level.
    assert_sleep_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (pwm_out == {NCH{inv}}));

    // R7 and R8: a channel that is not producing pulses drives the inactive level.
    assert_disabled_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwm_out ^ {NCH{inv}}) & ~(en & {NCH{run}})) == '0);

    // R9: the prescale value cannot change while awake.
    assert_presc_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep |=> $stable(presc));

    // R1: while running, the count holds or steps by one, wrapping at the top.
    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (!run || (cnt == $past(cnt)) || (cnt == CNT_W'($past(cnt) + 1'b1))));

    // R11: without run the count returns to zero and stays there.
    assert_count_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));
endmodule

bind pwm4_shadow pwm4_shadow_chk #(.NCH(NCH), .CNT_W(CNT_W), .PRE_W(PRE_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .sleep(sleep_w), .inv(inv_w), .run(run_w),
    .en(en_w), .presc(presc_w), .cnt(cnt_w), .pwm_out(pwm_out)
);

// File: tb/test_pwm4_shadow.sv
// Scoreboard bench: the driver queues expected channel-0 pulse widths and a
// negedge monitor measures each pulse and compares it with the queue.
module test_pwm4_shadow;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_wr = 1'b0;
    logic       xact_end = 1'b0;
    logic [3:0] pwm_out;

    int n_chk = 0, n_fail = 0;
    int exp_q[$];
    bit mon_on = 1'b0, mon_prev = 1'b0, done = 1'b0;
    int hw = 0;

    always #5 clk = ~clk;

    pwm4_shadow i_pwm4_shadow (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .xact_end(xact_end), .pwm_out(pwm_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(input int a, input int d);
        @(negedge clk);
        reg_addr = 8'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic end_x();
        @(negedge clk); xact_end = 1'b1;
        @(negedge clk); xact_end = 1'b0;
    endtask

    task automatic set_ch(input int c, input int on, input int off, input bit fin);
        wr_reg(8 + 4*c, on & 255);
        wr_reg(9 + 4*c, on >> 8);
        wr_reg(10 + 4*c, off & 255);
        wr_reg(11 + 4*c, off >> 8);
        if (fin) end_x();
    endtask

    task automatic meas_high(input int ch, input int win, output int hi);
        hi = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (pwm_out[ch]) hi++;
        end
    endtask

    task automatic wait_rise(input int ch);
        bit p;
        @(negedge clk); p = pwm_out[ch];
        forever begin
            @(negedge clk);
            if (pwm_out[ch] && !p) break;
            p = pwm_out[ch];
        end
    endtask

    task automatic spacing(input int ch, output int n);
        bit p;
        wait_rise(ch);
        n = 0; p = 1'b1;
        forever begin
            @(negedge clk); n++;
            if (pwm_out[ch] && !p) break;
            p = pwm_out[ch];
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // Monitor: measures channel-0 pulses and pops the expected widths.
    always @(negedge clk) begin
        if (mon_on) begin
            if (pwm_out[0]) hw++;
            if (mon_prev && !pwm_out[0]) begin
                if (exp_q.size() != 0) begin
                    int e;
                    e = exp_q.pop_front();
                    check(hw == e, "R4/R5/R6 pulse width", hw, e);
                end
                hw = 0;
            end
            mon_prev = pwm_out[0];
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(pwm_out == 4'h0, "R10 reset asleep inactive", pwm_out, 0);

        // Program while asleep; idle channels commit at once (R4, R3 map).
        set_ch(0, 100, 1100, 1'b1);
        set_ch(1, 12'h200, 12'h100, 1'b1);
        set_ch(2, 500, 500, 1'b1);
        set_ch(3, 10, 2000, 1'b1);
        wr_reg(1, 4'b0111);

        // R11: awake without restart stays inactive.
        wr_reg(0, 8'h00);
        meas_high(0, 1000, v); check(v == 0, "R11 no restart ch0", v, 0);
        check(pwm_out == 4'h0, "R11 no restart all", pwm_out, 0);

        wr_reg(0, 8'h08);
        mon_on = 1'b1;
        exp_q.push_back(1000); exp_q.push_back(1000);
        drain();
        meas_high(1, 4096, v); check(v == 3840, "R2 wrap ch1", v, 3840);
        meas_high(2, 4096, v); check(v == 0, "R2 on equals off ch2", v, 0);
        meas_high(3, 4096, v); check(v == 0, "R7 disabled ch3", v, 0);

        // R4: rewrite during a high phase; that pulse completes unchanged.
        exp_q.push_back(1000); exp_q.push_back(300); exp_q.push_back(300);
        wait_rise(0);
        repeat (200) @(negedge clk);
        set_ch(0, 100, 400, 1'b1);
        drain();

        // R5: bytes without the end pulse do nothing.
        set_ch(0, 100, 150, 1'b0);
        exp_q.push_back(300); exp_q.push_back(300);
        drain();
        end_x();
        exp_q.push_back(50); exp_q.push_back(50);
        drain();

        // R6: acknowledge mode, partial set held despite an end pulse.
        wr_reg(0, 8'h04);
        wr_reg(8, 100); wr_reg(9, 0); wr_reg(10, 700 & 255);
        end_x();
        exp_q.push_back(50); exp_q.push_back(50);
        drain();
        wr_reg(11, 700 >> 8);
        exp_q.push_back(600); exp_q.push_back(600);
        drain();
        mon_on = 1'b0;

        // R8: invert flips the inactive and active levels.
        wr_reg(0, 8'h06);
        @(negedge clk);
        check(pwm_out[3] == 1'b1, "R8 disabled ch3 inverted", pwm_out[3], 1);
        meas_high(0, 4096, v); check(v == 3496, "R8 inverted ch0", v, 3496);
        meas_high(2, 4096, v); check(v == 4096, "R8 inverted idle ch2", v, 4096);
        wr_reg(0, 8'h04);

        // R9: prescale write while awake is ignored.
        wr_reg(2, 1);
        spacing(0, v); check(v == 4096, "R9 awake prescale ignored", v, 4096);

        // R10: sleep forces inactive; then prescale write is accepted.
        wr_reg(0, 8'h05);
        @(negedge clk);
        check(pwm_out == 4'h0, "R10 asleep inactive", pwm_out, 0);
        wr_reg(2, 1);
        wr_reg(0, 8'h04);
        meas_high(0, 2000, v); check(v == 0, "R11 wake without restart", v, 0);
        wr_reg(0, 8'h0C);
        spacing(0, v); check(v == 8192, "R1 R9 period with prescale 1", v, 8192);
        meas_high(0, 8192, v); check(v == 1200, "R2 R11 kept values ch0", v, 1200);
        meas_high(1, 8192, v); check(v == 7680, "R1 shared prescale ch1", v, 7680);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule